// File: doc/BRIEF.md
# Subsystem Power-Down Sequencer

This block takes a processor subsystem from running to fully powered down in a fixed and safe order. A single start pulse launches the teardown. First the sequencer quiesces the core's bus port with a halt request and acknowledge handshake. It then stops the core clock and clamps the outputs. It drops memory standby and retention, and switches the memory banks off one at a time in ascending order. Last, it clamps memory, opens the head switch and polls the switch's status until it reports off. Only then does it assert the subsystem reset and after it the core reset.

Every wait is a parameter counted in clock cycles: the halt timeout, the gap between banks, the head-switch settle time, the poll interval and the poll limit. When the bus port fails to go idle, the sequencer records a sticky fault flag and carries on. When the head switch never reports off, the sequencer stops without asserting any reset and gives an error pulse. A successful teardown ends with a done pulse.

Top module: `ss_teardown_seq`

## Requirements
- R1: After reset the outputs show a running subsystem. halt_req_o=0, clk_en_o=1, io_clamp_o=0, wl_clamp_o=0, l2_stby_n_o=1, slp_ret_n_o=1, every bank_pwr_o bit=1, mem_clamp_o=0, hs_en_o=1, both resets=0, busy_o=0, done_o=0, err_o=0, halt_fault_o=0.
- R2: A start seen while idle with port_idle_i high skips the halt handshake; halt_req_o stays 0. With port_idle_i low, halt_req_o rises at that edge. It stays high until halt_ack_i is seen or HALT_TMO edges pass, and it falls at the edge after that.
- R3: The edge that drops halt_req_o loads halt_fault_o with the inverse of port_idle_i. The flag holds until the next accepted start, and the teardown continues in either case.
- R4: On successive edges after the halt phase, clk_en_o falls, then io_clamp_o rises, then wl_clamp_o rises, then l2_stby_n_o falls, then slp_ret_n_o falls.
- R5: Bank 0 switches off one edge after retention drops. Bank k+1 switches off BANK_WAIT edges after bank k. Each step clears exactly one bank_pwr_o bit, bit k for bank k.
- R6: mem_clamp_o rises BANK_WAIT edges after the last bank. hs_en_o falls on the next edge. hs_status_i is first sampled SETTLE edges later and then every POLL_GAP edges.
- R7: If hs_status_i reads high on POLL_MAX samples in a row, err_o pulses on the last sample edge. Neither reset is asserted, and the block returns to idle.
- R8: On the first sample where hs_status_i reads low, ss_rst_o rises at the next edge. core_rst_o rises one edge later, together with a done_o pulse.
- R9: done_o and err_o are single-cycle pulses and never coincide. busy_o is high from the accepted start until the done or error edge, and a start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch teardown (accepted only while idle) |
| port_idle_i | input | 1 | Bus port reports idle |
| halt_ack_i | input | 1 | Bus port acknowledges the halt request |
| hs_status_i | input | 1 | Head switch still on (high) or off (low) |
| halt_req_o | output | 1 | Halt request to the bus port |
| clk_en_o | output | 1 | Core clock enable |
| io_clamp_o | output | 1 | IO clamp |
| wl_clamp_o | output | 1 | Word-line clamp |
| l2_stby_n_o | output | 1 | L2 standby, active low |
| slp_ret_n_o | output | 1 | Sleep retention, active low |
| bank_pwr_o | output | NBANK | Per-bank memory power, bit k is bank k |
| mem_clamp_o | output | 1 | Memory clamp |
| hs_en_o | output | 1 | Head switch enable |
| ss_rst_o | output | 1 | Subsystem reset |
| core_rst_o | output | 1 | Core reset |
| busy_o | output | 1 | Teardown in progress |
| done_o | output | 1 | Successful completion pulse |
| err_o | output | 1 | Head-switch poll timeout pulse |
| halt_fault_o | output | 1 | Sticky: port not idle after the halt handshake |

## Verification
The bench covers four halt outcomes: a port that is already idle, an acknowledge that arrives early, an acknowledge that never comes and a port that stays busy. A design that got these wrong would pulse a halt request it did not need, end the wait one cycle off, or stop the sequence on a halt fault. The head switch is driven to read off on the very first sample, after several samples and never. These cases catch an off-by-one poll limit, resets that escape after a timeout, and a subsystem reset issued in the wrong order against the core reset. A start pulse arrives in the middle of the bank phase. A design that restarts on it would disturb the bank spacing, which the cycle-level model compares on every clock.

// File: rtl/td_pkg.sv
package td_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_HWAIT,
      ST_HCHK,
      ST_CLK,
      ST_IOC,
      ST_WLC,
      ST_STBY,
      ST_RET,
      ST_BANK,
      ST_MCL,
      ST_HSOFF,
      ST_POLL,
      ST_SSR,
      ST_CRST
   } td_state_e;

   function automatic int unsigned td_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/td_delay_timer.sv
module td_delay_timer #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] len,
   output logic         zero
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= len;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/td_bank_switch.sv
module td_bank_switch #(
   parameter int unsigned N  = 20,
   localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          off_stb,
   input  logic [IW-1:0] idx,
   output logic [N-1:0]  pwr
);

   for (genvar i = 0; i < N; i++) begin : g_bank
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pwr[i] <= 1'b1;
         else if (off_stb && (idx == IW'(i)))
            pwr[i] <= 1'b0;
      end
   end

endmodule

// File: rtl/ss_teardown_seq.sv
module ss_teardown_seq
   import td_pkg::*;
#(
   parameter int unsigned NBANK     = 20,
   parameter int unsigned HALT_TMO  = 64,
   parameter int unsigned BANK_WAIT = 50,
   parameter int unsigned SETTLE    = 2,
   parameter int unsigned POLL_GAP  = 50,
   parameter int unsigned POLL_MAX  = 200
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             port_idle_i,
   input  logic             halt_ack_i,
   input  logic             hs_status_i,
   output logic             halt_req_o,
   output logic             clk_en_o,
   output logic             io_clamp_o,
   output logic             wl_clamp_o,
   output logic             l2_stby_n_o,
   output logic             slp_ret_n_o,
   output logic [NBANK-1:0] bank_pwr_o,
   output logic             mem_clamp_o,
   output logic             hs_en_o,
   output logic             ss_rst_o,
   output logic             core_rst_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o,
   output logic             halt_fault_o
);

   localparam int unsigned MAXD = td_max(td_max(HALT_TMO, BANK_WAIT),
                                         td_max(SETTLE, POLL_GAP));
   localparam int unsigned TW   = $clog2(MAXD + 1);
   localparam int unsigned IW   = (NBANK > 1) ? $clog2(NBANK) : 1;
   localparam int unsigned PW   = $clog2(POLL_MAX + 1);

   if (NBANK < 2) begin : g_chk_nbank
      $error("NBANK must be at least 2");
   end
   if (HALT_TMO < 1 || BANK_WAIT < 1 || SETTLE < 1 || POLL_GAP < 1) begin : g_chk_delay
      $error("all delay parameters must be at least 1");
   end
   if (POLL_MAX < 1) begin : g_chk_poll
      $error("POLL_MAX must be at least 1");
   end

   td_state_e      state;
   logic [IW-1:0]  bank_idx;
   logic [PW-1:0]  poll_cnt;
   logic           tmr_load;
   logic [TW-1:0]  tmr_len;
   logic           tmr_zero;
   logic           bank_off;

   td_delay_timer #(.W(TW)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .len   (tmr_len),
      .zero  (tmr_zero)
   );

   td_bank_switch #(.N(NBANK)) u_banks (
      .clk     (clk),
      .rst_n   (rst_n),
      .off_stb (bank_off),
      .idx     (bank_idx),
      .pwr     (bank_pwr_o)
   );

   // timer loads and bank strobes for the current state
   always_comb begin
      tmr_load = 1'b0;
      tmr_len  = '0;
      bank_off = 1'b0;
      unique case (state)
         ST_IDLE: begin
            if (start_i && !port_idle_i) begin
               tmr_load = 1'b1;
               tmr_len  = TW'(HALT_TMO - 1);
            end
         end
         ST_RET: begin
            tmr_load = 1'b1;
         end
         ST_BANK: begin
            if (tmr_zero) begin
               bank_off = 1'b1;
               tmr_load = 1'b1;
               tmr_len  = TW'(BANK_WAIT - 1);
            end
         end
         ST_HSOFF: begin
            tmr_load = 1'b1;
            tmr_len  = TW'(SETTLE - 1);
         end
         ST_POLL: begin
            if (tmr_zero && hs_status_i && (poll_cnt != PW'(POLL_MAX - 1))) begin
               tmr_load = 1'b1;
               tmr_len  = TW'(POLL_GAP - 1);
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         bank_idx     <= '0;
         poll_cnt     <= '0;
         halt_req_o   <= 1'b0;
         clk_en_o     <= 1'b1;
         io_clamp_o   <= 1'b0;
         wl_clamp_o   <= 1'b0;
         l2_stby_n_o  <= 1'b1;
         slp_ret_n_o  <= 1'b1;
         mem_clamp_o  <= 1'b0;
         hs_en_o      <= 1'b1;
         ss_rst_o     <= 1'b0;
         core_rst_o   <= 1'b0;
         done_o       <= 1'b0;
         err_o        <= 1'b0;
         halt_fault_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_i) begin
                  halt_fault_o <= 1'b0;
                  if (port_idle_i) begin
                     state <= ST_CLK;
                  end else begin
                     halt_req_o <= 1'b1;
                     state      <= ST_HWAIT;
                  end
               end
            end
            ST_HWAIT: begin
               if (halt_ack_i || tmr_zero)
                  state <= ST_HCHK;
            end
            ST_HCHK: begin
               halt_req_o   <= 1'b0;
               halt_fault_o <= !port_idle_i;
               state        <= ST_CLK;
            end
            ST_CLK: begin
               clk_en_o <= 1'b0;
               state    <= ST_IOC;
            end
            ST_IOC: begin
               io_clamp_o <= 1'b1;
               state      <= ST_WLC;
            end
            ST_WLC: begin
               wl_clamp_o <= 1'b1;
               state      <= ST_STBY;
            end
            ST_STBY: begin
               l2_stby_n_o <= 1'b0;
               state       <= ST_RET;
            end
            ST_RET: begin
               slp_ret_n_o <= 1'b0;
               bank_idx    <= '0;
               state       <= ST_BANK;
            end
            ST_BANK: begin
               if (tmr_zero) begin
                  if (bank_idx == IW'(NBANK - 1))
                     state <= ST_MCL;
                  else
                     bank_idx <= bank_idx + 1'b1;
               end
            end
            ST_MCL: begin
               if (tmr_zero) begin
                  mem_clamp_o <= 1'b1;
                  state       <= ST_HSOFF;
               end
            end
            ST_HSOFF: begin
               hs_en_o  <= 1'b0;
               poll_cnt <= '0;
               state    <= ST_POLL;
            end
            ST_POLL: begin
               if (tmr_zero) begin
                  if (!hs_status_i) begin
                     state <= ST_SSR;
                  end else if (poll_cnt == PW'(POLL_MAX - 1)) begin
                     err_o <= 1'b1;
                     state <= ST_IDLE;
                  end else begin
                     poll_cnt <= poll_cnt + 1'b1;
                  end
               end
            end
            ST_SSR: begin
               ss_rst_o <= 1'b1;
               state    <= ST_CRST;
            end
            ST_CRST: begin
               core_rst_o <= 1'b1;
               done_o     <= 1'b1;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy_o = (state != ST_IDLE);

endmodule

// File: rtl/td_seq_checker.sv
module td_seq_checker #(
   parameter int unsigned NBANK = 20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             halt_req_o,
   input logic             clk_en_o,
   input logic             io_clamp_o,
   input logic [NBANK-1:0] bank_pwr_o,
   input logic             mem_clamp_o,
   input logic             hs_en_o,
   input logic             ss_rst_o,
   input logic             core_rst_o,
   input logic             busy_o,
   input logic             done_o,
   input logic             err_o
);

   AST_IDLE_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> !halt_req_o); // R2

   AST_HALT_BEFORE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clk_en_o) |-> !halt_req_o); // R2

   AST_CLK_BEFORE_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_clamp_o) |-> !clk_en_o); // R4

   AST_ONE_BANK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_pwr_o != $past(bank_pwr_o)) |->
         ($countones($past(bank_pwr_o) & ~bank_pwr_o) == 1)); // R5

   AST_SWITCH_OFF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ss_rst_o) |-> (!hs_en_o && mem_clamp_o && (bank_pwr_o == '0))); // R6

   AST_ERR_KEEPS_RST: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> ($stable(ss_rst_o) && $stable(core_rst_o))); // R7

   AST_RST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(core_rst_o) |-> $past(ss_rst_o)); // R8

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o)); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R9

   AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> !err_o); // R9

endmodule

bind ss_teardown_seq td_seq_checker #(.NBANK(NBANK)) u_td_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .halt_req_o  (halt_req_o),
   .clk_en_o    (clk_en_o),
   .io_clamp_o  (io_clamp_o),
   .bank_pwr_o  (bank_pwr_o),
   .mem_clamp_o (mem_clamp_o),
   .hs_en_o     (hs_en_o),
   .ss_rst_o    (ss_rst_o),
   .core_rst_o  (core_rst_o),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .err_o       (err_o)
);

// File: tb/ss_teardown_seq_test.sv
`timescale 1ns/1ps
module ss_teardown_seq_test;

   localparam int NB = 20;
   localparam int HT = 10;
   localparam int BW = 5;
   localparam int ST = 3;
   localparam int PG = 4;
   localparam int PM = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic port_idle = 1'b1;
   logic halt_ack = 1'b0;
   logic hs_status = 1'b1;

   logic          halt_req, clk_en, io_clamp, wl_clamp, l2_stby_n, slp_ret_n;
   logic [NB-1:0] bank_pwr;
   logic          mem_clamp, hs_en, ss_rst, core_rst, busy, done, err, halt_fault;

   always #10 clk = ~clk;

   ss_teardown_seq #(
      .NBANK(NB), .HALT_TMO(HT), .BANK_WAIT(BW),
      .SETTLE(ST), .POLL_GAP(PG), .POLL_MAX(PM)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .port_idle_i(port_idle), .halt_ack_i(halt_ack), .hs_status_i(hs_status),
      .halt_req_o(halt_req), .clk_en_o(clk_en), .io_clamp_o(io_clamp),
      .wl_clamp_o(wl_clamp), .l2_stby_n_o(l2_stby_n), .slp_ret_n_o(slp_ret_n),
      .bank_pwr_o(bank_pwr), .mem_clamp_o(mem_clamp), .hs_en_o(hs_en),
      .ss_rst_o(ss_rst), .core_rst_o(core_rst), .busy_o(busy),
      .done_o(done), .err_o(err), .halt_fault_o(halt_fault)
   );

   int checks = 0;
   int fails  = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- plant model: bus port and head switch ----------------
   int  ack_lat  = -1;   // cycles from halt request to acknowledge, -1 never
   bit  idle_on_ack = 0; // port goes idle once acknowledged
   bit  force_idle  = 1;
   int  hs_lat   = 0;    // cycles from head-switch off to status low, -1 never
   int  req_cnt  = 0;
   int  hs_cnt   = 0;
   bit  idle_latch = 0;

   always @(negedge clk) begin
      if (halt_req) req_cnt <= req_cnt + 1; else req_cnt <= 0;
      halt_ack <= halt_req && (ack_lat >= 0) && (req_cnt >= ack_lat);
      if (halt_ack && idle_on_ack) idle_latch <= 1;
      port_idle <= force_idle || idle_latch || (halt_ack && idle_on_ack);
      if (hs_en) begin
         hs_cnt    <= 0;
         hs_status <= 1'b1;
      end else begin
         hs_cnt    <= hs_cnt + 1;
         hs_status <= (hs_lat < 0) || (hs_cnt < hs_lat);
      end
   end

   // ---------------- behavioural reference model ----------------
   logic          e_hreq, e_clk, e_io, e_wl, e_stby, e_ret, e_mcl, e_hs;
   logic          e_ss, e_core, e_busy, e_done, e_err, e_fault;
   logic [NB-1:0] e_bank;

   task automatic model_reset();
      e_hreq = 0; e_clk = 1; e_io = 0; e_wl = 0; e_stby = 1; e_ret = 1;
      e_bank = '1; e_mcl = 0; e_hs = 1; e_ss = 0; e_core = 0;
      e_busy = 0; e_done = 0; e_err = 0; e_fault = 0;
   endtask

   task automatic model_run();
      int j;
      int p;
      e_busy = 1;
      e_fault = 0;
      if (!port_idle) begin
         e_hreq = 1;
         j = 1;
         forever begin
            @(posedge clk);
            if (halt_ack || j >= HT) break;
            j++;
         end
         @(posedge clk);
         e_fault = !port_idle;
         e_hreq  = 0;
      end
      @(posedge clk); e_clk  = 0;
      @(posedge clk); e_io   = 1;
      @(posedge clk); e_wl   = 1;
      @(posedge clk); e_stby = 0;
      @(posedge clk); e_ret  = 0;
      for (int i = 0; i < NB; i++) begin
         if (i == 0) @(posedge clk);
         else repeat (BW) @(posedge clk);
         e_bank[i] = 1'b0;
      end
      repeat (BW) @(posedge clk);
      e_mcl = 1;
      @(posedge clk);
      e_hs = 0;
      repeat (ST) @(posedge clk);
      p = 0;
      forever begin
         if (!hs_status) begin
            @(posedge clk); e_ss = 1;
            @(posedge clk); e_core = 1; e_done = 1; e_busy = 0;
            break;
         end else if (p == PM - 1) begin
            e_err = 1; e_busy = 0;
            break;
         end
         p++;
         repeat (PG) @(posedge clk);
      end
   endtask

   initial begin
      model_reset();
      forever begin
         @(posedge clk);
         e_done = 0;
         e_err  = 0;
         if (!rst_n) model_reset();
         else if (start) model_run();
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(halt_req == e_hreq, "R2 halt_req", halt_req, e_hreq);
         chk(halt_fault == e_fault, "R3 halt_fault", halt_fault, e_fault);
         chk({clk_en, io_clamp, wl_clamp, l2_stby_n, slp_ret_n} ==
             {e_clk, e_io, e_wl, e_stby, e_ret}, "R4 clock/clamp/standby",
             {clk_en, io_clamp, wl_clamp, l2_stby_n, slp_ret_n},
             {e_clk, e_io, e_wl, e_stby, e_ret});
         chk(bank_pwr == e_bank, "R5 bank_pwr", bank_pwr, e_bank);
         chk({mem_clamp, hs_en} == {e_mcl, e_hs}, "R6 mem_clamp/hs_en",
             {mem_clamp, hs_en}, {e_mcl, e_hs});
         chk(err == e_err, "R7 err", err, e_err);
         chk({ss_rst, core_rst, done} == {e_ss, e_core, e_done}, "R8 resets/done",
             {ss_rst, core_rst, done}, {e_ss, e_core, e_done});
         chk(busy == e_busy, "R9 busy", busy, e_busy);
      end
   end

   // ---------------- stimulus ----------------
   task automatic apply_reset();
      @(negedge clk);
      rst_n = 1'b0;
      idle_latch = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({halt_req, clk_en, io_clamp, wl_clamp, l2_stby_n, slp_ret_n} == 6'b010011,
          "R1 control reset", {halt_req, clk_en, io_clamp, wl_clamp, l2_stby_n, slp_ret_n}, 6'b010011);
      chk(bank_pwr == '1, "R1 banks reset", bank_pwr, {NB{1'b1}});
      chk({mem_clamp, hs_en, ss_rst, core_rst, busy, done, err, halt_fault} == 8'b01000000,
          "R1 misc reset", {mem_clamp, hs_en, ss_rst, core_rst, busy, done, err, halt_fault}, 8'b01000000);
   endtask

   // runs one teardown; returns 1 for done, 2 for error
   task automatic run_seq(input bit poke_mid, output int outcome);
      int n_done;
      int cyc;
      n_done = 0;
      cyc = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      outcome = 0;
      while (outcome == 0 && cyc < 5000) begin
         if (poke_mid && cyc == 60) start = 1'b1;
         else start = 1'b0;
         if (done) begin outcome = 1; n_done++; end
         if (err) outcome = 2;
         @(negedge clk);
         cyc++;
      end
      start = 1'b0;
      // R9 pulses are one cycle
      chk(!done && !err, "R9 pulse width", {done, err}, 0);
      repeat (4) @(negedge clk);
   endtask

   initial begin
      int oc;
      // A: port already idle, head switch off after two cycles, start poked mid-run
      force_idle = 1; idle_on_ack = 0; ack_lat = -1; hs_lat = 2;
      apply_reset();
      run_seq(1'b1, oc);
      chk(oc == 1, "R8 idle-port run completes", oc, 1);
      chk(core_rst && ss_rst, "R8 resets held", {ss_rst, core_rst}, 3);
      chk(!busy, "R9 start while busy ignored", busy, 0);

      // B: port busy, acknowledges after 3 cycles and goes idle
      force_idle = 0; idle_on_ack = 1; ack_lat = 3; hs_lat = 6;
      apply_reset();
      run_seq(1'b0, oc);
      chk(oc == 1, "R2 early ack run completes", oc, 1);
      chk(!halt_fault, "R3 no fault after clean halt", halt_fault, 0);

      // C: port never acknowledges, never idle; head switch off at first poll
      force_idle = 0; idle_on_ack = 0; ack_lat = -1; hs_lat = 0;
      apply_reset();
      run_seq(1'b0, oc);
      chk(oc == 1, "R3 sequence continues after halt fault", oc, 1);
      chk(halt_fault, "R3 fault recorded", halt_fault, 1);

      // D: head switch stuck on
      force_idle = 1; idle_on_ack = 0; ack_lat = -1; hs_lat = -1;
      apply_reset();
      run_seq(1'b0, oc);
      chk(oc == 2, "R7 poll timeout error", oc, 2);
      chk(!ss_rst && !core_rst, "R7 no reset after error", {ss_rst, core_rst}, 0);

      // E: head switch off late, near the poll limit
      force_idle = 1; hs_lat = ST + (PM - 2) * PG;
      apply_reset();
      run_seq(1'b0, oc);
      chk(oc != 0, "R6 late switch-off finishes", oc, 1);

      // F: acknowledge arrives but port remains busy
      force_idle = 0; idle_on_ack = 0; ack_lat = 1; hs_lat = 1;
      apply_reset();
      run_seq(1'b0, oc);
      chk(halt_fault, "R3 fault despite ack", halt_fault, 1);
      chk(oc == 1, "R8 completes after faulted halt", oc, 1);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule